// File: doc/BRIEF.md
# Multi-Mode Host Parallel Port

This block is the host side of a byte-wide parallel port. It drives eight data lines, a small group of control outputs, a direction output for the external data buffers, and an output enable for the host's own data drivers. It also takes in a group of peripheral status lines. A CPU reaches it over a simple single-cycle register bus. A mode register chooses how the port behaves:

- **Legacy:** the port only sends bytes from host to peripheral.
- **Bidirectional:** a direction bit turns the data lines around in either direction.
- **Enhanced:** the port runs hardware-timed cycles.

In enhanced mode, one register write launches a complete address or data transfer over the same eight lines. The sequencer moves the write line and the data, then pulses the address strobe or the data strobe. It follows the peripheral's wait line through both of its edges. If the wait line does not answer in time, the sequencer gives up and records a sticky timeout.

A single enable input gives the pins to this port. While the enable is low, every output is inactive and no cycle can start.

Top module: `pport_top`

## Requirements
- R1: After reset, all of the following hold:
  - the mode field (offset 3, bits 1:0) reads 0, which is legacy;
  - the DATA (offset 0) and CONTROL (offset 2) registers read 0;
  - the timeout limit (offset 4) reads TMO_RESET;
  - the timeout flag (STATUS offset 1, bit 6) reads 0.
- R2: In legacy mode (mode 0, and also mode 3) with the port enabled:
  - a byte written to DATA appears on pd_out after the write's clock edge;
  - pd_oe is 1 and buf_dir is 0;
  - the direction bit (CONTROL bit 5) has no effect on pd_oe or buf_dir.
- R3: In bidirectional mode (mode 1):
  - with CONTROL bit 5 clear, pd_oe is 1 and buf_dir is 0;
  - with CONTROL bit 5 set, pd_oe is 0, buf_dir is 1, and a DATA read returns pd_in;
  - pd_oe and buf_dir are never 1 at the same time.
- R4: While enabled, ctl_out follows CONTROL bits 3:0. A STATUS read returns the following bits:
  - bits 4:0: sts_in;
  - bit 6: the timeout flag;
  - bit 7: sequencer busy.
- R5: In enhanced mode (mode 2), a write to offset 5 runs an address write cycle and a write to offset 6 runs a data write cycle.
  - One setup clock comes first, with wr_n low and the byte on pd_out and pd_oe 1.
  - Then astb_n (address cycle) or dstb_n (data cycle) goes low. The two strobes are never low together.
- R6: In enhanced mode, a write to offset 7 runs a read cycle: an address read when bit 0 is 0, a data read when bit 0 is 1.
  - Throughout the cycle, wr_n is high, pd_oe is 0 and buf_dir is 1.
  - pd_in is captured on the clock edge where wait is first seen high. The captured byte reads back at offset 7.
- R7: A strobe stays low until wait is seen high, then rises. The sequencer stays busy until wait is seen low, and only then returns to idle.
- R8: When a strobe phase (waiting for wait high) or a release phase (waiting for wait low) lasts limit+1 clocks without the expected wait level, the following happens:
  - the cycle ends;
  - all strobes go high;
  - the timeout flag (STATUS bit 6) is set.
  The flag stays set until a STATUS write with bit 6 set clears it.
- R9: While port_en is 0, all of the following hold:
  - pd_oe, buf_dir, pd_out and ctl_out are 0;
  - wr_n, astb_n and dstb_n are high;
  - writes to offsets 5 to 7 start no cycle, and busy stays 0.
- R10: A cycle start written while the sequencer is busy is ignored. A cycle start written in a mode other than enhanced is also ignored, and the strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Grants the shared pins to this port |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pd_in | input | 8 | Data lines as seen from the pins |
| pd_out | output | 8 | Data driven toward the pins |
| pd_oe | output | 1 | Host data driver enable |
| buf_dir | output | 1 | External buffer direction, 1 = peripheral to host |
| ctl_out | output | 4 | Control outputs |
| sts_in | input | 5 | Peripheral status inputs |
| wr_n | output | 1 | Enhanced cycle write line, low = write |
| astb_n | output | 1 | Address strobe, active low |
| dstb_n | output | 1 | Data strobe, active low |
| wait_in | input | 1 | Peripheral wait handshake |

## Verification
Register writes and the legacy and bidirectional pin levels settle from the clock edge that takes the write, so the bench looks at them on the falling edge right after it. Register reads are combinational and are sampled one time step after the address is set.

An enhanced cycle pulls its strobe low two edges after the launching write. A scoreboard queue holds the expected strobe kind, direction and byte, and a falling-edge monitor compares them on the first low strobe sample.

Handshake steps are checked one edge after the bench changes wait. Timeouts are checked several clocks beyond the limit+1 clocks that each phase is allowed.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned CTL_W = 4;
  localparam int unsigned STS_W = 5;
  localparam int unsigned AW    = 3;

  typedef enum logic [1:0] {M_LEGACY = 2'd0, M_BIDIR = 2'd1, M_ENH = 2'd2, M_RSVD = 2'd3} mode_t;
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} seq_t;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_CTRL = 3'd2;
  localparam logic [AW-1:0] A_MODE = 3'd3;
  localparam logic [AW-1:0] A_LIM  = 3'd4;
  localparam logic [AW-1:0] A_EADR = 3'd5;
  localparam logic [AW-1:0] A_EDAT = 3'd6;
  localparam logic [AW-1:0] A_ERD  = 3'd7;

  // a phase has run out once its counter reaches the limit
  function automatic logic phase_expired(input logic [15:0] cnt, input logic [15:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int unsigned TMO_W     = 8,
  parameter int unsigned TMO_RESET = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    pd_in,
  input  logic [STS_W-1:0] sts_in,
  input  logic             seq_busy,
  input  logic [DW-1:0]    cap_data,
  input  logic             tmo_evt,
  output mode_t            mode_q,
  output logic [DW-1:0]    data_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             dir_q,
  output logic [TMO_W-1:0] limit_q,
  output logic             start,
  output logic             start_addr,
  output logic             start_read,
  output logic [DW-1:0]    start_byte,
  output logic             tmo_sticky
);
  logic wr_hit, cyc_reg;
  assign wr_hit  = sel && wr;
  assign cyc_reg = (addr == A_EADR) || (addr == A_EDAT) || (addr == A_ERD);

  assign start      = wr_hit && cyc_reg && en && (mode_q == M_ENH) && !seq_busy;
  assign start_addr = (addr == A_EADR) || ((addr == A_ERD) && !wdata[0]);
  assign start_read = (addr == A_ERD);
  assign start_byte = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_LEGACY;
      data_q     <= '0;
      ctl_q      <= '0;
      dir_q      <= 1'b0;
      limit_q    <= TMO_W'(TMO_RESET);
      tmo_sticky <= 1'b0;
    end else begin
      if (wr_hit) begin
        case (addr)
          A_DATA: data_q <= wdata;
          A_CTRL: begin ctl_q <= wdata[CTL_W-1:0]; dir_q <= wdata[5]; end
          A_MODE: mode_q <= mode_t'(wdata[1:0]);
          A_LIM:  limit_q <= wdata[TMO_W-1:0];
          A_STAT: if (wdata[6]) tmo_sticky <= 1'b0;
          default: ;
        endcase
      end
      if (tmo_evt) tmo_sticky <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA: rdata = (mode_q == M_BIDIR && dir_q) ? pd_in : data_q;
      A_STAT: rdata = {seq_busy, tmo_sticky, {(DW-1-STS_W-1){1'b0}}, sts_in};
      A_CTRL: rdata = {2'b00, dir_q, 1'b0, ctl_q};
      A_MODE: rdata = {6'd0, mode_q};
      A_LIM:  rdata = DW'(limit_q);
      A_ERD:  rdata = cap_data;
      default: rdata = '0;
    endcase
  end

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n) tmo_evt |=> tmo_sticky);
endmodule

// File: rtl/pport_seq.sv
module pport_seq
  import pport_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             start_addr,
  input  logic             start_read,
  input  logic [DW-1:0]    start_byte,
  input  logic [TMO_W-1:0] limit,
  input  logic             wait_in,
  input  logic [DW-1:0]    pd_in,
  output logic             busy,
  output logic             wr_act,
  output logic             rd_act,
  output logic             astb_act,
  output logic             dstb_act,
  output logic [DW-1:0]    wbyte_q,
  output logic [DW-1:0]    cap_q,
  output logic             tmo_evt
);
  seq_t             state;
  logic [TMO_W-1:0] cnt;
  logic             is_addr_q, is_read_q;
  logic             strobe_on, expired, strobe_to, hold_to;

  assign expired   = phase_expired(16'(cnt), 16'(limit));
  assign strobe_on = (state == S_STROBE);
  assign strobe_to = strobe_on && !wait_in && expired;
  assign hold_to   = (state == S_HOLD) && wait_in && expired;
  assign tmo_evt   = en && (strobe_to || hold_to);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      is_addr_q <= 1'b0;
      is_read_q <= 1'b0;
      wbyte_q   <= '0;
      cap_q     <= '0;
    end else if (!en) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_SETUP;
          is_addr_q <= start_addr;
          is_read_q <= start_read;
          if (!start_read) wbyte_q <= start_byte;
          cnt       <= '0;
        end
        S_SETUP: begin state <= S_STROBE; cnt <= '0; end
        S_STROBE: begin
          if (wait_in) begin
            state <= S_HOLD;
            cnt   <= '0;
            if (is_read_q) cap_q <= pd_in;
          end else if (expired) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (!wait_in || expired) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign astb_act = strobe_on && is_addr_q;
  assign dstb_act = strobe_on && !is_addr_q;
  assign wr_act   = busy && !is_read_q;
  assign rd_act   = busy && is_read_q;

  // R5
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $past(state) == S_SETUP);
  // R7
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_on) |-> ($past(wait_in) || $past(tmo_evt) || !$past(en)));
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/pport_pins.sv
module pport_pins
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  mode_t            mode,
  input  logic             dir,
  input  logic [DW-1:0]    data_q,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic [DW-1:0]    wbyte,
  input  logic             wr_act,
  input  logic             rd_act,
  input  logic             astb_act,
  input  logic             dstb_act,
  output logic [DW-1:0]    pd_out,
  output logic             pd_oe,
  output logic             buf_dir,
  output logic [CTL_W-1:0] ctl_out,
  output logic             wr_n,
  output logic             astb_n,
  output logic             dstb_n
);
  always_comb begin
    pd_out  = '0;
    pd_oe   = 1'b0;
    buf_dir = 1'b0;
    ctl_out = '0;
    wr_n    = 1'b1;
    astb_n  = 1'b1;
    dstb_n  = 1'b1;
    if (en) begin
      ctl_out = ctl_q;
      case (mode)
        M_BIDIR: begin pd_out = data_q; pd_oe = !dir; buf_dir = dir; end
        M_ENH: begin
          pd_out  = wbyte;
          pd_oe   = wr_act;
          buf_dir = rd_act;
          wr_n    = !wr_act;
          astb_n  = !astb_act;
          dstb_n  = !dstb_act;
        end
        default: begin pd_out = data_q; pd_oe = 1'b1; end
      endcase
    end
  end

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pd_oe && !buf_dir && astb_n && dstb_n && wr_n));
  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_oe && buf_dir));
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    astb_n || dstb_n);
endmodule

// File: rtl/pport_top.sv
module pport_top
  import pport_pkg::*;
#(
  parameter int unsigned TMO_W     = 8,
  parameter int unsigned TMO_RESET = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW-1:0]    pd_in,
  output logic [DW-1:0]    pd_out,
  output logic             pd_oe,
  output logic             buf_dir,
  output logic [CTL_W-1:0] ctl_out,
  input  logic [STS_W-1:0] sts_in,
  output logic             wr_n,
  output logic             astb_n,
  output logic             dstb_n,
  input  logic             wait_in
);
  mode_t            mode_q;
  logic [DW-1:0]    data_q, start_byte, wbyte_q, cap_q;
  logic [CTL_W-1:0] ctl_q;
  logic [TMO_W-1:0] limit_q;
  logic dir_q, start, start_addr, start_read, tmo_sticky;
  logic busy, wr_act, rd_act, astb_act, dstb_act, tmo_evt;

  pport_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(port_en), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .pd_in(pd_in),
    .sts_in(sts_in), .seq_busy(busy), .cap_data(cap_q), .tmo_evt(tmo_evt),
    .mode_q(mode_q), .data_q(data_q), .ctl_q(ctl_q), .dir_q(dir_q),
    .limit_q(limit_q), .start(start), .start_addr(start_addr),
    .start_read(start_read), .start_byte(start_byte), .tmo_sticky(tmo_sticky));

  pport_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(port_en), .start(start),
    .start_addr(start_addr), .start_read(start_read), .start_byte(start_byte),
    .limit(limit_q), .wait_in(wait_in), .pd_in(pd_in), .busy(busy),
    .wr_act(wr_act), .rd_act(rd_act), .astb_act(astb_act), .dstb_act(dstb_act),
    .wbyte_q(wbyte_q), .cap_q(cap_q), .tmo_evt(tmo_evt));

  pport_pins u_pins (
    .clk(clk), .rst_n(rst_n), .en(port_en), .mode(mode_q), .dir(dir_q),
    .data_q(data_q), .ctl_q(ctl_q), .wbyte(wbyte_q), .wr_act(wr_act),
    .rd_act(rd_act), .astb_act(astb_act), .dstb_act(dstb_act),
    .pd_out(pd_out), .pd_oe(pd_oe), .buf_dir(buf_dir), .ctl_out(ctl_out),
    .wr_n(wr_n), .astb_n(astb_n), .dstb_n(dstb_n));
endmodule

// File: tb/pport_top_tb.sv
module pport_top_tb;
  localparam int unsigned CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, port_en = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, pd_in = '0, pd_out;
  logic pd_oe, buf_dir, wr_n, astb_n, dstb_n, wait_in = 1'b0;
  logic [3:0] ctl_out;
  logic [4:0] sts_in = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0, resp_on = 0, strobe_prev = 0;
  logic [7:0] rd;

  typedef struct packed { logic is_addr; logic is_read; logic [7:0] b; } item_t;
  item_t sb[$];
  item_t it;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_top u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .buf_dir(buf_dir), .ctl_out(ctl_out), .sts_in(sts_in), .wr_n(wr_n),
    .astb_n(astb_n), .dstb_n(dstb_n), .wait_in(wait_in));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  // driver side of the scoreboard: expected strobe cycle
  task automatic expect_cyc(input logic a, input logic r, input logic [7:0] b);
    sb.push_back({a, r, b});
  endtask

  // peripheral responder
  always @(negedge clk) if (resp_on) wait_in = !astb_n || !dstb_n;

  // monitor: compare on first low strobe sample
  always @(negedge clk) begin
    if ((!astb_n || !dstb_n) && !strobe_prev) begin
      if (sb.size() == 0) chk("R5 unexpected strobe", 1, 0);
      else begin
        it = sb.pop_front();
        chk("R5 strobe kind astb", {31'd0, !astb_n}, {31'd0, it.is_addr});
        if (!it.is_read) begin
          chk("R5 wr_n low", {31'd0, wr_n}, 0);
          chk("R5 byte on pd_out", {24'd0, pd_out}, {24'd0, it.b});
          chk("R5 pd_oe", {31'd0, pd_oe}, 1);
        end else begin
          chk("R6 wr_n high", {31'd0, wr_n}, 1);
          chk("R6 pd_oe off", {31'd0, pd_oe}, 0);
          chk("R6 buf_dir in", {31'd0, buf_dir}, 1);
        end
      end
    end
    strobe_prev = !astb_n || !dstb_n;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    brd(3'd3, rd); chk("R1 mode", rd, 0);
    brd(3'd0, rd); chk("R1 data", rd, 0);
    brd(3'd2, rd); chk("R1 control", rd, 0);
    brd(3'd4, rd); chk("R1 limit", rd, 16);
    brd(3'd1, rd); chk("R1 timeout flag", {31'd0, rd[6]}, 0);

    // R2 legacy
    bwr(3'd0, 8'h5A);
    chk("R2 pd_out", pd_out, 8'h5A);
    chk("R2 pd_oe", pd_oe, 1); chk("R2 buf_dir", buf_dir, 0);
    bwr(3'd2, 8'h20);
    chk("R2 dir ignored pd_oe", pd_oe, 1); chk("R2 dir ignored buf_dir", buf_dir, 0);
    bwr(3'd6, 8'h33);
    @(negedge clk);
    chk("R10 no strobe in legacy", {30'd0, astb_n, dstb_n}, 3);
    brd(3'd1, rd); chk("R10 not busy in legacy", rd[7], 0);

    // R4 control and status
    bwr(3'd2, 8'h0B);
    chk("R4 ctl_out", ctl_out, 4'hB);
    sts_in = 5'h15;
    brd(3'd1, rd); chk("R4 status bits", rd[4:0], 5'h15);

    // R3 bidirectional
    bwr(3'd3, 8'h01);
    chk("R3 drive pd_oe", pd_oe, 1); chk("R3 drive buf_dir", buf_dir, 0);
    bwr(3'd2, 8'h2B);
    pd_in = 8'hC3;
    chk("R3 input pd_oe", pd_oe, 0); chk("R3 input buf_dir", buf_dir, 1);
    brd(3'd0, rd); chk("R3 data reads pins", rd, 8'hC3);
    bwr(3'd3, 8'h03);
    chk("R2 mode 3 acts legacy", pd_oe, 1);

    // R5 enhanced writes via scoreboard
    bwr(3'd3, 8'h02);
    resp_on = 1;
    expect_cyc(1, 0, 8'h81); bwr(3'd5, 8'h81);
    repeat (6) @(negedge clk);
    expect_cyc(0, 0, 8'h7E); bwr(3'd6, 8'h7E);
    repeat (6) @(negedge clk);
    brd(3'd1, rd); chk("R5 idle after cycle", rd[7], 0);

    // R6 enhanced read
    pd_in = 8'hA5;
    expect_cyc(0, 1, 8'h00); bwr(3'd7, 8'h01);
    repeat (6) @(negedge clk);
    pd_in = 8'h00;
    brd(3'd7, rd); chk("R6 captured byte", rd, 8'hA5);
    pd_in = 8'h3C;
    expect_cyc(1, 1, 8'h00); bwr(3'd7, 8'h00);
    repeat (6) @(negedge clk);
    brd(3'd7, rd); chk("R6 address read capture", rd, 8'h3C);
    resp_on = 0; wait_in = 0;

    // R7 handshake by hand, R10 busy ignore
    bwr(3'd4, 8'd50);
    expect_cyc(1, 0, 8'h11); bwr(3'd5, 8'h11);
    bwr(3'd6, 8'h22);
    repeat (3) @(negedge clk);
    chk("R7 strobe held without wait", astb_n, 0);
    chk("R10 second start ignored", {dstb_n, pd_out}, {1'b1, 8'h11});
    wait_in = 1;
    @(negedge clk);
    chk("R7 strobe released after wait", astb_n, 1);
    brd(3'd1, rd); chk("R7 busy until wait low", rd[7], 1);
    wait_in = 0;
    repeat (2) @(negedge clk);
    brd(3'd1, rd); chk("R7 idle after wait low", rd[7], 0);
    chk("R10 queue drained", sb.size(), 0);

    // R8 timeout
    bwr(3'd4, 8'd4);
    expect_cyc(0, 0, 8'h44); bwr(3'd6, 8'h44);
    repeat (10) @(negedge clk);
    brd(3'd1, rd); chk("R8 cycle ended", rd[7], 0); chk("R8 sticky set", rd[6], 1);
    chk("R8 strobes high", {astb_n, dstb_n}, 2'b11);
    repeat (3) @(negedge clk);
    brd(3'd1, rd); chk("R8 still sticky", rd[6], 1);
    bwr(3'd1, 8'h40);
    brd(3'd1, rd); chk("R8 cleared", rd[6], 0);

    // R9 disabled
    port_en = 0;
    #1;
    chk("R9 pd_oe", pd_oe, 0); chk("R9 buf_dir", buf_dir, 0);
    chk("R9 ctl_out", ctl_out, 0); chk("R9 pd_out", pd_out, 0);
    chk("R9 strobes and wr_n", {astb_n, dstb_n, wr_n}, 3'b111);
    bwr(3'd5, 8'h99);
    @(negedge clk);
    brd(3'd1, rd); chk("R9 no cycle when off", rd[7], 0);
    chk("R9 no strobe when off", astb_n, 1);
    port_en = 1;
    repeat (2) @(negedge clk);
    chk("R9 scoreboard empty", sb.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule